// File: doc/BRIEF.md
# Link Initialization Silence Sequencer

This block starts up a serial link port. It begins in a quiet phase with the transmit driver switched off. Because no idle symbols go out during that phase, the far end loses lane sync and is pushed back into its own start-up sequence, whatever state it was in. The quiet phase has to be long enough that the partner really does restart. It also has to be short enough that nobody mistakes it for a broken link. Its length is a whole number of units. Each unit is `SIL_UNIT` (410 by default) service ticks, and the number of units comes from a programmed value.

When the quiet phase ends, the port enters a discovery phase. A second timer, clocked by the same service tick, watches that phase. If discovery finishes in time, the sequencer settles in the active state. If the timer runs out first, the sequencer flags a timeout and goes back to the quiet phase. A restart request from any state sends the sequencer straight back to a fresh quiet phase.

The states are SILENT (code 0), DISCOVERY (code 1) and ACTIVE (code 2). The transitions are:
- reset → SILENT
- SILENT → DISCOVERY when the silence time has elapsed
- DISCOVERY → ACTIVE on `disc_done`
- DISCOVERY → SILENT on discovery expiry
- any state → SILENT on `restart`

Top module: `link_silence_seq`

## Requirements
- R1: After reset, `state` is 0 (SILENT), `tx_en` is 0 and `disc_timeout` is 0.
- R2: `tx_en` is 0 in every cycle in which `state` is SILENT (0), and 1 in every cycle in which `state` is DISCOVERY (1) or ACTIVE (2).
- R3: Once SILENT is entered, the sequencer moves to DISCOVERY in the cycle after the `SIL_UNIT` × N-th cycle in which `tick` is high, where N is the effective silence value. Cycles with `tick` low do not advance the count. `sil_val` must stay steady while it is in use.
- R4: A `sil_val` of 0 acts as 1.
- R5: A `sil_val` above `SIL_CAP` (12) acts as `SIL_CAP`.
- R6: In DISCOVERY, `disc_done` high (with no restart) puts the sequencer in ACTIVE on the next cycle.
- R7: In DISCOVERY, the cycle after the M-th `tick` shows state SILENT and `disc_timeout` high for exactly one cycle. M is `disc_val`, with 0 acting as 1 and values capped at `DISC_CAP`. A new full silence period follows.
- R8: When `disc_done` coincides with the discovery-expiry tick, the sequencer goes to ACTIVE and `disc_timeout` stays 0.
- R9: `restart` in any state gives state SILENT on the next cycle, with `disc_timeout` 0 even on an expiry cycle. The silence count restarts from zero, so a full silence period follows.
- R10: ACTIVE is held for as long as `restart` is low, and `disc_done` has no effect outside DISCOVERY.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | Service tick, one-cycle enable for both timers |
| sil_val | input | SIL_W (4) | Programmed silence length in units of SIL_UNIT ticks |
| disc_val | input | DISC_W (6) | Programmed discovery limit in ticks |
| restart | input | 1 | Restart request, returns to SILENT |
| disc_done | input | 1 | Discovery completed |
| tx_en | output | 1 | Transmit driver enable |
| state | output | 2 | Current state: 0 SILENT, 1 DISCOVERY, 2 ACTIVE |
| disc_timeout | output | 1 | One-cycle pulse on discovery expiry |

## Verification
Three events can land in the same cycle: the discovery timer's last tick, the completion signal and a restart request. These collisions are where an ordering mistake would show. The bench uses its own model's tick count to place `disc_done` exactly on the expiring tick, then does the same with `restart`. It judges both cases by the state and timeout flag on the next cycle: completion must beat expiry, and restart must beat both without raising the flag. A restart in the middle of a silence period is also checked to make sure a complete new silence period follows.

// File: rtl/lss_pkg.sv
package lss_pkg;
    typedef enum logic [1:0] {
        ST_SILENT   = 2'd0,
        ST_DISCOVER = 2'd1,
        ST_ACTIVE   = 2'd2
    } lss_state_e;
endpackage

// File: rtl/lss_clamp.sv
// Maps a programmed value to its effective value: zero becomes one,
// anything above CAP becomes CAP.
module lss_clamp #(
    parameter int W   = 4,
    parameter int CAP = 12
) (
    input  logic [W-1:0] raw,
    output logic [W-1:0] eff
);
    localparam logic [W-1:0] CAP_V = W'(CAP);

    always_comb begin
        if (raw == '0)
            eff = W'(1);
        else if (raw > CAP_V)
            eff = CAP_V;
        else
            eff = raw;
    end
endmodule

// File: rtl/lss_tick_timer.sv
// Counts service ticks in groups of PRE; expires on the tick that
// completes LIMIT groups. PRE == 1 drops the prescaler entirely.
module lss_tick_timer #(
    parameter int PRE = 410,
    parameter int CW  = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          run,
    input  logic          tick,
    input  logic [CW-1:0] limit,
    output logic          expire
);
    localparam int PW = (PRE > 1) ? $clog2(PRE) : 1;

    logic [CW-1:0] units_q;
    logic          pre_last;
    logic          step;

    assign step = run && tick;

    generate
        if (PRE > 1) begin : g_pre
            localparam logic [PW-1:0] PRE_TOP = PW'(PRE - 1);
            logic [PW-1:0] pre_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    pre_q <= '0;
                else if (clr)
                    pre_q <= '0;
                else if (step)
                    pre_q <= (pre_q == PRE_TOP) ? '0 : pre_q + 1'b1;
            end
            assign pre_last = (pre_q == PRE_TOP);
        end else begin : g_nopre
            assign pre_last = 1'b1;
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            units_q <= '0;
        else if (clr)
            units_q <= '0;
        else if (step && pre_last)
            units_q <= units_q + 1'b1;
    end

    assign expire = step && pre_last && (units_q == limit - 1'b1);
endmodule

// File: rtl/link_silence_seq.sv
module link_silence_seq #(
    parameter int SIL_W    = 4,
    parameter int SIL_CAP  = 12,
    parameter int SIL_UNIT = 410,
    parameter int DISC_W   = 6,
    parameter int DISC_CAP = 63
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic [SIL_W-1:0]  sil_val,
    input  logic [DISC_W-1:0] disc_val,
    input  logic              restart,
    input  logic              disc_done,
    output logic              tx_en,
    output logic [1:0]        state,
    output logic              disc_timeout
);
    import lss_pkg::*;

    lss_state_e        st_q, st_d;
    logic              to_q, to_d;
    logic [SIL_W-1:0]  sil_eff;
    logic [DISC_W-1:0] disc_eff;
    logic              sil_exp, disc_exp;
    logic              in_sil, in_disc;

    assign in_sil  = (st_q == ST_SILENT);
    assign in_disc = (st_q == ST_DISCOVER);

    lss_clamp #(.W(SIL_W), .CAP(SIL_CAP)) u_sil_clamp (
        .raw(sil_val), .eff(sil_eff)
    );
    lss_clamp #(.W(DISC_W), .CAP(DISC_CAP)) u_disc_clamp (
        .raw(disc_val), .eff(disc_eff)
    );

    lss_tick_timer #(.PRE(SIL_UNIT), .CW(SIL_W)) u_sil_tmr (
        .clk(clk), .rst_n(rst_n),
        .clr(!in_sil || restart), .run(in_sil),
        .tick(tick), .limit(sil_eff), .expire(sil_exp)
    );
    lss_tick_timer #(.PRE(1), .CW(DISC_W)) u_disc_tmr (
        .clk(clk), .rst_n(rst_n),
        .clr(!in_disc || restart), .run(in_disc),
        .tick(tick), .limit(disc_eff), .expire(disc_exp)
    );

    // Next-state decision: restart first, then completion, then expiry.
    always_comb begin
        st_d = st_q;
        to_d = 1'b0;
        if (restart) begin
            st_d = ST_SILENT;
        end else begin
            unique case (st_q)
                ST_SILENT:   if (sil_exp) st_d = ST_DISCOVER;
                ST_DISCOVER: begin
                    if (disc_done) begin
                        st_d = ST_ACTIVE;
                    end else if (disc_exp) begin
                        st_d = ST_SILENT;
                        to_d = 1'b1;
                    end
                end
                ST_ACTIVE:   st_d = ST_ACTIVE;
                default:     st_d = ST_SILENT;
            endcase
        end
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= ST_SILENT;
            to_q <= 1'b0;
        end else begin
            st_q <= st_d;
            to_q <= to_d;
        end
    end

    // Outputs.
    always_comb begin
        state        = st_q;
        disc_timeout = to_q;
        unique case (st_q)
            ST_SILENT:   tx_en = 1'b0;
            ST_DISCOVER: tx_en = 1'b1;
            ST_ACTIVE:   tx_en = 1'b1;
            default:     tx_en = 1'b0;
        endcase
    end
endmodule

// File: rtl/link_silence_seq_chk.sv
module link_silence_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       restart,
    input logic       disc_done,
    input logic       tx_en,
    input logic [1:0] state,
    input logic       disc_timeout
);
    assert_restart_silent_R9: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (state == 2'd0 && !tx_en && !disc_timeout));

    assert_timeout_in_silent_R7: assert property (@(posedge clk) disable iff (!rst_n)
        disc_timeout |-> (state == 2'd0 && !tx_en));

    assert_timeout_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        disc_timeout |=> !disc_timeout);

    assert_done_to_active_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == 2'd1 && disc_done && !restart) |=> (state == 2'd2 && !disc_timeout));

    assert_active_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == 2'd2 && !restart) |=> state == 2'd2);

    assert_silent_exit_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == 2'd0 && !restart) |=> (state == 2'd0 || state == 2'd1));

    assert_legal_state_R2: assert property (@(posedge clk) disable iff (!rst_n)
        state != 2'd3);
endmodule

bind link_silence_seq link_silence_seq_chk u_chk (
    .clk(clk), .rst_n(rst_n), .restart(restart), .disc_done(disc_done),
    .tx_en(tx_en), .state(state), .disc_timeout(disc_timeout)
);

// File: tb/link_silence_seq_bench.sv
module link_silence_seq_bench;
    localparam int UNIT = 410;
    localparam int SCAP = 12;
    localparam int DCAP = 63;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b1;
    logic [3:0] sil_val = 4'd1;
    logic [5:0] disc_val = 6'd5;
    logic       restart = 1'b0;
    logic       disc_done = 1'b0;
    logic       tx_en;
    logic [1:0] state;
    logic       disc_timeout;

    int    n_chk = 0;
    int    n_bad = 0;
    string cur_req = "R1";

    // model state
    int m_st = 0;
    int m_to = 0;
    int m_sil = 0;
    int m_dt = 0;

    always #4 clk = ~clk;

    link_silence_seq u_link_silence_seq (
        .clk(clk), .rst_n(rst_n), .tick(tick), .sil_val(sil_val),
        .disc_val(disc_val), .restart(restart), .disc_done(disc_done),
        .tx_en(tx_en), .state(state), .disc_timeout(disc_timeout)
    );

    function automatic int eff_of(int v, int cap);
        if (v == 0) return 1;
        if (v > cap) return cap;
        return v;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // behavioural reference, advanced on each rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = 0; m_to = 0; m_sil = 0; m_dt = 0;
        end else if (restart) begin
            m_st = 0; m_to = 0; m_sil = 0; m_dt = 0;
        end else begin
            m_to = 0;
            case (m_st)
                0: if (tick) begin
                    m_sil++;
                    if (m_sil == UNIT * eff_of(sil_val, SCAP)) begin
                        m_st = 1; m_dt = 0;
                    end
                end
                1: if (disc_done) begin
                    m_st = 2;
                end else if (tick) begin
                    m_dt++;
                    if (m_dt == eff_of(disc_val, DCAP)) begin
                        m_st = 0; m_sil = 0; m_to = 1;
                    end
                end
                default: m_st = 2;
            endcase
        end
    end

    // per-cycle comparison, away from the edge
    always @(posedge clk) begin
        #3;
        if (rst_n) begin
            chk(state == 2'(m_st), {cur_req, " state"}, state, m_st);
            chk(tx_en == (m_st != 0), "R2 tx_en", tx_en, m_st != 0);
            chk(disc_timeout == 1'(m_to), {cur_req, " disc_timeout"}, disc_timeout, m_to);
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_restart();
        restart = 1'b1; cyc(1); restart = 1'b0;
    endtask

    // count cycles shown in SILENT starting from the cycle after a restart
    task automatic measure_silence(output int n);
        n = 0;
        do_restart();
        while (state == 2'd0) begin n++; cyc(1); end
    endtask

    task automatic wait_state(input int s);
        while (state != 2'(s)) cyc(1);
    endtask

    initial begin
        #(8 * 150000);
        n_bad++; n_chk++;
        $display("FAIL watchdog: actual 0 expected 1");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        int n;
        cyc(2);
        chk(state == 2'd0 && !tx_en && !disc_timeout, "R1 reset", state, 0);
        rst_n = 1'b1;
        cyc(1);
        chk(state == 2'd0 && !tx_en, "R1 after release", state, 0);

        // R3 / R7: one unit of silence, discovery expires after 5 ticks
        cur_req = "R3";
        measure_silence(n);
        chk(n == UNIT, "R3 silence length", n, UNIT);
        cur_req = "R7";
        cyc(3);
        chk(state == 2'd1 && tx_en, "R7 in discovery", state, 1);
        wait_state(0);
        chk(disc_timeout == 1'b1, "R7 timeout pulse", disc_timeout, 1);
        cyc(1);
        chk(disc_timeout == 1'b0 && state == 2'd0, "R7 pulse ends", disc_timeout, 0);

        // R3 with gapped ticks
        cur_req = "R3";
        restart = 1'b1; cyc(1); restart = 1'b0;
        n = 0;
        while (state == 2'd0) begin tick = ~tick; n++; cyc(1); end
        tick = 1'b1;
        chk(n >= 2 * UNIT - 1 && n <= 2 * UNIT + 1, "R3 gapped ticks", n, 2 * UNIT);

        // R4: zero acts as one; R6 completion; R10 hold
        cur_req = "R4";
        sil_val = 4'd0;
        measure_silence(n);
        chk(n == UNIT, "R4 zero silence", n, UNIT);
        cur_req = "R6";
        cyc(1);
        disc_done = 1'b1; cyc(1);
        chk(state == 2'd2 && tx_en, "R6 active", state, 2);
        cur_req = "R10";
        cyc(50);
        disc_done = 1'b0; cyc(20);
        chk(state == 2'd2, "R10 hold", state, 2);

        // R5: cap
        cur_req = "R5";
        sil_val = 4'd15;
        measure_silence(n);
        chk(n == UNIT * SCAP, "R5 capped silence", n, UNIT * SCAP);
        sil_val = 4'd1;

        // R8: completion on the expiry tick
        cur_req = "R8";
        disc_val = 6'd3;
        do_restart();
        while (!(m_st == 1 && m_dt == 2)) cyc(1);
        disc_done = 1'b1; cyc(1); disc_done = 1'b0;
        chk(state == 2'd2 && !disc_timeout, "R8 done beats expiry", state, 2);

        // R9: restart on the expiry tick
        cur_req = "R9";
        do_restart();
        while (!(m_st == 1 && m_dt == 2)) cyc(1);
        restart = 1'b1; cyc(1); restart = 1'b0;
        chk(state == 2'd0 && !disc_timeout, "R9 restart beats expiry", disc_timeout, 0);

        // R9: restart mid-silence gives a full new period
        sil_val = 4'd2;
        do_restart();
        cyc(300);
        measure_silence(n);
        chk(n == 2 * UNIT, "R9 full silence after restart", n, 2 * UNIT);

        // R10: disc_done ignored in SILENT
        cur_req = "R10";
        do_restart();
        disc_done = 1'b1; cyc(30); disc_done = 1'b0;
        chk(state == 2'd0, "R10 done ignored in SILENT", state, 0);

        // R7: discovery value zero acts as one tick
        cur_req = "R7";
        disc_val = 6'd0;
        sil_val = 4'd1;
        do_restart();
        wait_state(1);
        cyc(1);
        chk(state == 2'd0 && disc_timeout, "R7 zero discovery limit", state, 0);
        cyc(5);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule